// File: doc/BRIEF.md
# Circular Instruction Trace Recorder

This block captures instructions as the processor retires them and keeps them in a ring of 128-bit lines. Each retire strobe packs the opcode, the word-aligned program counter, a result or data word, the trap and error-mode flags and the current time tag into one line. An atomic load/store takes two consecutive lines. The first carries the loaded value. The second carries the stored value and sets a continuation flag.

A debug host reaches the ring and one control register through a word-addressed port. The host can reach them only while the processor is halted. While the processor runs, host writes are discarded and host reads return zero. While the processor is halted, capture is frozen. The control register holds an enable bit, a per-class filter on instruction types, and the index of the next line to be written.

The behaviour is driven by a three-state machine:
- `ST_TRACE` records instructions while the processor runs.
- `ST_PAIR` writes the second half of an atomic access.
- `ST_DEBUG` is the halted state that owns the host port.

The transitions are:
- `ST_TRACE` moves to `ST_DEBUG` when `dbg_mode` is high.
- `ST_TRACE` moves to `ST_PAIR` when it records an atomic instruction.
- `ST_PAIR` always leaves after one cycle. It goes to `ST_DEBUG` when `dbg_mode` is high, otherwise back to `ST_TRACE`.
- `ST_DEBUG` returns to `ST_TRACE` when `dbg_mode` falls.

Top module: `trace_recorder`

## Requirements
- R1: A stored line holds the following fields:
  - bits 31:0: opcode
  - bit 32: error-mode flag
  - bit 33: trap flag
  - bits 63:34: PC[31:2]
  - bits 95:64: data
  - bits 125:96: time tag
  - bit 126: continuation flag
  - bit 127: zero

  Host word k of a line (address bits [3:2] = k) is bits 32k+31:32k.
- R2: Each stored line advances the write index by one, modulo the depth. After line DEPTH-1 the next line goes to line 0.
- R3: A recorded atomic instruction writes two consecutive lines with the same opcode, PC, trap and error-mode values:
  - The first line holds the load data and has bit 126 clear.
  - The second line, written on the next cycle, holds the store data and has bit 126 set.
  - The time tag of each line is sampled at its own write.
- R4: In `ST_DEBUG` no retire strobe writes a line or moves the index.
- R5: In `ST_DEBUG`, the host can read and write every word of every line and the control register, including presetting the index. Host read data appears on the cycle after the request.
- R6: Outside `ST_DEBUG`, host writes to lines and to the control register change nothing.
- R7: Outside `ST_DEBUG`, host reads return zero.
- R8: The filter field sits at control bits [4+NTYPE-1:4]. An instruction of class k is recorded only when filter bit k is set.
- R9: With the enable bit (control bit 0) clear, nothing is recorded.
- R10: After reset, the state is `ST_TRACE`, enable is 0, the filter is all ones, the index is 0 and `host_rdata` is 0. The index sits at control bits [16+IDX_W-1:16].
- R11: The control register is at byte address 1<<(IDX_W+4). Line n, word k is at (n<<4)|(k<<2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_mode | input | 1 | Processor halted in debug mode |
| ret_valid | input | 1 | Instruction retired this cycle |
| ret_atomic | input | 1 | Retired instruction is an atomic load/store |
| ret_itype | input | TY_W | Instruction class, 0..NTYPE-1 |
| ret_opcode | input | 32 | Opcode |
| ret_pc | input | 30 | Program counter bits 31:2 |
| ret_data | input | 32 | Result, store address, or load data for an atomic access |
| ret_store_data | input | 32 | Store data for an atomic access |
| ret_trap | input | 1 | Instruction trapped |
| ret_err | input | 1 | Instruction caused error mode |
| time_tag | input | 30 | Free-running time tag |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | IDX_W+3 | Byte address bits [IDX_W+4:2] |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |

## Verification
The assertions assume the following about the inputs:
- No retire strobe arrives on the cycle after an atomic instruction is recorded, because the recorder spends that cycle on the second line.
- `ret_itype` stays below NTYPE.

The stimulus keeps within these assumptions:
- Every retire strobe is one cycle long.
- The inputs stay idle for a full cycle after an atomic strobe.
- Only classes 0 to 3 are used.
- Host accesses are made only after `dbg_mode` has been held long enough for the state to reach `ST_DEBUG`, except in the scenario that deliberately probes the lockout.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        ST_TRACE = 2'd0,
        ST_PAIR  = 2'd1,
        ST_DEBUG = 2'd2
    } trc_state_e;

    typedef struct packed {
        logic        spare;
        logic        second;
        logic [29:0] tag;
        logic [31:0] data;
        logic [29:0] pc;
        logic        trap;
        logic        errm;
        logic [31:0] opc;
    } trc_line_t;

    localparam int LINE_W        = 128;
    localparam int WORD_N        = 4;
    localparam int TAG_W         = 30;
    localparam int CTRL_FILT_LSB = 4;
    localparam int CTRL_IDX_LSB  = 16;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NTYPE = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TY_W  = $clog2(NTYPE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_mode,
    input  logic             ret_valid,
    input  logic             ret_atomic,
    input  logic [TY_W-1:0]  ret_itype,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic [NTYPE-1:0] cfg_filt,
    input  logic [IDX_W-1:0] cfg_idx,
    output trc_state_e       state_o,
    output logic             trace_we,
    output logic             trace_second,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      ctrl_word
);

    trc_state_e       state_q, state_d;
    logic             en_q;
    logic [NTYPE-1:0] filt_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit;

    assign hit = ret_valid && en_q && filt_q[ret_itype];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACE: begin
                if (dbg_mode)                state_d = ST_DEBUG;
                else if (hit && ret_atomic)  state_d = ST_PAIR;
            end
            ST_PAIR:  state_d = dbg_mode ? ST_DEBUG : ST_TRACE;
            ST_DEBUG: if (!dbg_mode)         state_d = ST_TRACE;
            default:  state_d = ST_TRACE;
        endcase
    end

    // Outputs
    always_comb begin
        trace_we     = 1'b0;
        trace_second = 1'b0;
        unique case (state_q)
            ST_TRACE: trace_we = hit && !dbg_mode;
            ST_PAIR: begin
                trace_we     = 1'b1;
                trace_second = 1'b1;
            end
            ST_DEBUG: trace_we = 1'b0;
            default:  trace_we = 1'b0;
        endcase
    end

    // Control register: host load only when halted, else index steps per line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            filt_q <= '1;
            idx_q  <= '0;
        end else if (cfg_wr && state_q == ST_DEBUG) begin
            en_q   <= cfg_en;
            filt_q <= cfg_filt;
            idx_q  <= cfg_idx;
        end else if (trace_we) begin
            idx_q  <= (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[0] = en_q;
        ctrl_word[CTRL_FILT_LSB +: NTYPE] = filt_q;
        ctrl_word[CTRL_IDX_LSB +: IDX_W]  = idx_q;
    end

    assign state_o = state_q;
    assign wr_idx  = idx_q;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        trace_we |=> idx_q == (($past(idx_q) == IDX_W'(DEPTH - 1)) ? '0 : $past(idx_q) + 1'b1)); // R2
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEBUG) |-> !trace_we); // R4
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DEBUG) |=> $stable(en_q) && $stable(filt_q)); // R6

endmodule

// File: rtl/trace_store.sv
module trace_store
    import trace_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_N-1:0] wmask,
    input  logic [LINE_W-1:0] wline,
    input  logic [IDX_W-1:0]  ridx,
    output logic [LINE_W-1:0] rline
);

    for (genvar g = 0; g < WORD_N; g++) begin : g_lane
        logic [31:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) lane_mem[widx] <= wline[32*g +: 32];
        end

        assign rline[32*g +: 32] = lane_mem[ridx];
    end

endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
    import trace_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NTYPE = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TY_W  = $clog2(NTYPE),
    localparam int HA_W  = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode,
    input  logic              ret_valid,
    input  logic              ret_atomic,
    input  logic [TY_W-1:0]   ret_itype,
    input  logic [31:0]       ret_opcode,
    input  logic [31:2]       ret_pc,
    input  logic [31:0]       ret_data,
    input  logic [31:0]       ret_store_data,
    input  logic              ret_trap,
    input  logic              ret_err,
    input  logic [TAG_W-1:0]  time_tag,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [HA_W-1:2]   host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata
);

    trc_state_e        state;
    logic              trace_we, trace_second;
    logic [IDX_W-1:0]  wr_idx;
    logic [31:0]       ctrl_word;
    logic              host_ok, host_ctrl, cfg_wr, hbuf_we;
    logic [IDX_W-1:0]  host_line;
    logic [1:0]        host_word;
    trc_line_t         first_line, pair_q, trace_line;
    logic              st_we;
    logic [IDX_W-1:0]  st_widx;
    logic [WORD_N-1:0] st_mask;
    logic [LINE_W-1:0] st_wline, st_rline;

    assign host_ok   = (state == ST_DEBUG);
    assign host_ctrl = host_addr[HA_W-1];
    assign host_line = host_addr[4 +: IDX_W];
    assign host_word = host_addr[3:2];
    assign cfg_wr    = host_sel && host_wr && host_ctrl;
    assign hbuf_we   = host_sel && host_wr && !host_ctrl && host_ok;

    trace_ctrl #(.DEPTH(DEPTH), .NTYPE(NTYPE)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_mode     (dbg_mode),
        .ret_valid    (ret_valid),
        .ret_atomic   (ret_atomic),
        .ret_itype    (ret_itype),
        .cfg_wr       (cfg_wr),
        .cfg_en       (host_wdata[0]),
        .cfg_filt     (host_wdata[CTRL_FILT_LSB +: NTYPE]),
        .cfg_idx      (host_wdata[CTRL_IDX_LSB +: IDX_W]),
        .state_o      (state),
        .trace_we     (trace_we),
        .trace_second (trace_second),
        .wr_idx       (wr_idx),
        .ctrl_word    (ctrl_word)
    );

    // Line for a plain instruction or the first half of an atomic pair
    always_comb begin
        first_line        = '0;
        first_line.tag    = time_tag;
        first_line.data   = ret_data;
        first_line.pc     = ret_pc;
        first_line.trap   = ret_trap;
        first_line.errm   = ret_err;
        first_line.opc    = ret_opcode;
    end

    // Second half: held fields plus the store data, stamped when written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else if (trace_we && !trace_second) begin
            pair_q        <= first_line;
            pair_q.data   <= ret_store_data;
            pair_q.second <= 1'b1;
        end
    end

    always_comb begin
        trace_line = trace_second ? pair_q : first_line;
        if (trace_second) trace_line.tag = time_tag;
    end

    // One storage write port: host when halted, trace otherwise
    always_comb begin
        if (hbuf_we) begin
            st_we    = 1'b1;
            st_widx  = host_line;
            st_mask  = WORD_N'(1) << host_word;
            st_wline = {WORD_N{host_wdata}};
        end else begin
            st_we    = trace_we;
            st_widx  = wr_idx;
            st_mask  = '1;
            st_wline = trace_line;
        end
    end

    trace_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (st_we),
        .widx  (st_widx),
        .wmask (st_mask),
        .wline (st_wline),
        .ridx  (host_line),
        .rline (st_rline)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else begin
            host_rdata <= '0;
            if (host_sel && !host_wr && host_ok)
                host_rdata <= host_ctrl ? ctrl_word : st_rline[{host_word, 5'b0} +: 32];
        end
    end

    AST_PAIR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        trace_second |-> $past(trace_we) && !$past(trace_second)); // R3
    AST_RD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && state != ST_DEBUG) |=> host_rdata == 32'h0); // R7

endmodule

// File: tb/tb_trace_recorder.sv
module tb_trace_recorder;

    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int HA_W  = IDX_W + 5;
    localparam logic [31:0] CTRL_A = 32'(1) << (IDX_W + 4);

    logic clk = 1'b0, rst_n = 1'b0, dbg_mode = 1'b0;
    logic ret_valid = 1'b0, ret_atomic = 1'b0, ret_trap = 1'b0, ret_err = 1'b0;
    logic [1:0]  ret_itype = '0;
    logic [31:0] ret_opcode = '0, ret_data = '0, ret_store_data = '0;
    logic [31:2] ret_pc = '0;
    logic [29:0] time_tag = '0;
    logic host_sel = 1'b0, host_wr = 1'b0;
    logic [HA_W-1:2] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;

    int checks = 0, errors = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    trace_recorder dut (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .ret_valid(ret_valid),
        .ret_atomic(ret_atomic), .ret_itype(ret_itype), .ret_opcode(ret_opcode),
        .ret_pc(ret_pc), .ret_data(ret_data), .ret_store_data(ret_store_data),
        .ret_trap(ret_trap), .ret_err(ret_err), .time_tag(time_tag),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [31:0] a, input logic [31:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a[HA_W-1:2]; host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hread(input logic [31:0] a, output logic [31:0] d);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a[HA_W-1:2];
        @(posedge clk); @(negedge clk);
        host_sel = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [31:0] la(input int line, input int word);
        return 32'((line << 4) | (word << 2));
    endfunction

    task automatic set_dbg(input logic v);
        dbg_mode = v;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic retire(input logic [31:0] opc, input logic [31:0] pc, input logic [31:0] dat,
                          input logic [31:0] st, input logic trap, input logic err,
                          input logic atom, input logic [1:0] ity, input logic [29:0] tag);
        ret_valid = 1'b1; ret_opcode = opc; ret_pc = pc[31:2]; ret_data = dat;
        ret_store_data = st; ret_trap = trap; ret_err = err; ret_atomic = atom;
        ret_itype = ity; time_tag = tag;
        @(posedge clk); @(negedge clk);
        ret_valid = 1'b0; ret_atomic = 1'b0;
        if (atom) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic t_reset();
        chk("R10 rdata", host_rdata, 32'h0);
        set_dbg(1'b1);
        hread(CTRL_A, rd); chk("R10 ctrl", rd, 32'h0000_00F0);
    endtask

    task automatic t_basic();
        hwrite(CTRL_A, 32'h0000_00F1);
        set_dbg(1'b0);
        retire(32'hA000_0001, 32'h4000_0010, 32'h1111_1111, 32'h0, 1'b1, 1'b0, 1'b0, 2'd0, 30'h0ABC);
        retire(32'hB000_0002, 32'h4000_0014, 32'h2222_2222, 32'h0, 1'b0, 1'b1, 1'b0, 2'd1, 30'h0ABD);
        retire(32'hC000_0003, 32'h4000_0018, 32'h3333_3333, 32'h0, 1'b0, 1'b0, 1'b0, 2'd3, 30'h0ABE);
        set_dbg(1'b1);
        hread(CTRL_A, rd);   chk("R2 R5 idx after 3", rd, 32'h0003_00F1);
        hread(la(0, 0), rd); chk("R1 opcode", rd, 32'hA000_0001);
        hread(la(0, 1), rd); chk("R1 pc/trap/err", rd, {30'h1000_0004, 1'b1, 1'b0});
        hread(la(0, 2), rd); chk("R1 data", rd, 32'h1111_1111);
        hread(la(0, 3), rd); chk("R1 tag", rd, {2'b00, 30'h0ABC});
        hread(la(1, 1), rd); chk("R1 err bit", rd, {30'h1000_0005, 1'b0, 1'b1});
        hread(la(2, 0), rd); chk("R11 line2 addr", rd, 32'hC000_0003);
    endtask

    task automatic t_atomic();
        set_dbg(1'b0);
        retire(32'hD000_0004, 32'h4000_0020, 32'h5555_0000, 32'h6666_0000, 1'b0, 1'b0, 1'b1, 2'd1, 30'h0100);
        set_dbg(1'b1);
        hread(CTRL_A, rd);   chk("R3 idx +2", rd, 32'h0005_00F1);
        hread(la(3, 2), rd); chk("R3 load data", rd, 32'h5555_0000);
        hread(la(3, 3), rd); chk("R3 first flag", rd, {2'b00, 30'h0100});
        hread(la(4, 2), rd); chk("R3 store data", rd, 32'h6666_0000);
        hread(la(4, 3), rd); chk("R3 second flag", rd, {2'b01, 30'h0100});
        hread(la(4, 0), rd); chk("R3 same opcode", rd, 32'hD000_0004);
        hread(la(4, 1), rd); chk("R3 same pc", rd, {30'h1000_0008, 2'b00});
    endtask

    task automatic t_filter();
        hwrite(CTRL_A, 32'h0005_00B1);
        set_dbg(1'b0);
        retire(32'hE000_0005, 32'h4000_0030, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd2, 30'h0200);
        retire(32'hF000_0006, 32'h4000_0034, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1, 30'h0201);
        set_dbg(1'b1);
        hread(CTRL_A, rd);   chk("R8 one kept", rd, 32'h0006_00B1);
        hread(la(5, 0), rd); chk("R8 kept class", rd, 32'hF000_0006);
    endtask

    task automatic t_freeze();
        retire(32'h1234_0007, 32'h4000_0040, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 30'h0300);
        retire(32'h1234_0008, 32'h4000_0044, 32'h0, 32'h9, 1'b0, 1'b0, 1'b1, 2'd1, 30'h0301);
        hread(CTRL_A, rd); chk("R4 idx frozen", rd, 32'h0006_00B1);
    endtask

    task automatic t_lock();
        set_dbg(1'b0);
        hwrite(CTRL_A, 32'h0000_0000);
        hwrite(la(0, 0), 32'hDEAD_BEEF);
        hread(CTRL_A, rd);   chk("R7 run read zero", rd, 32'h0);
        set_dbg(1'b1);
        hread(CTRL_A, rd);   chk("R6 ctrl unchanged", rd, 32'h0006_00B1);
        hread(la(0, 0), rd); chk("R6 line unchanged", rd, 32'hA000_0001);
    endtask

    task automatic t_wrap();
        hwrite(CTRL_A, 32'h003F_00F1);
        set_dbg(1'b0);
        retire(32'h7700_0001, 32'h4000_0050, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 30'h0400);
        retire(32'h7700_0002, 32'h4000_0054, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 30'h0401);
        set_dbg(1'b1);
        hread(CTRL_A, rd);    chk("R2 wrap idx", rd, 32'h0001_00F1);
        hread(la(63, 0), rd); chk("R2 last line", rd, 32'h7700_0001);
        hread(la(0, 0), rd);  chk("R2 wrapped line", rd, 32'h7700_0002);
    endtask

    task automatic t_disable();
        hwrite(CTRL_A, 32'h0001_00F0);
        set_dbg(1'b0);
        retire(32'h8800_0001, 32'h4000_0060, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 30'h0500);
        set_dbg(1'b1);
        hread(CTRL_A, rd);   chk("R9 disabled idx", rd, 32'h0001_00F0);
        hread(la(1, 0), rd); chk("R9 line kept", rd, 32'hB000_0002);
    endtask

    task automatic t_host_buf();
        hwrite(la(10, 2), 32'h1234_5678);
        hread(la(10, 2), rd); chk("R5 host word write", rd, 32'h1234_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_atomic();
        t_filter();
        t_freeze();
        t_lock();
        t_wrap();
        t_disable();
        t_host_buf();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule